// File: doc/BRIEF.md
# Memory-Aware Warp Issue Scheduler

This block chooses, once per clock, which warp of a streaming core issues next. Each warp presents three flags: a buffered instruction is ready, that instruction is a memory access (otherwise it is compute), and that instruction waits on a load that has not returned. The memory side reports how many miss-status entries and how many miss-queue slots are in use. The result is a registered warp id with a valid bit. The current scheduling mode and the current owner warp are also brought out.

While the memory system has headroom, the scheduler runs in equal-priority mode. In this mode it keeps issuing from the warp it chose last. It falls back to the oldest eligible warp only when that warp cannot go on. Warp age follows warp index, so the lower index is older. When either occupancy reaches its high threshold, the scheduler enters memory-priority mode. In this mode a single owner warp holds the right to issue memory instructions, and every other warp may issue only compute instructions.

Ownership moves when the owner's next instruction waits on its own outstanding load. The new owner is the oldest warp with a ready memory instruction that has no such dependency. The scheduler returns to equal-priority mode only after both occupancies drop below separate low thresholds.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high, `issue_valid`, `sched_mem_mode` and `owner_valid` are 0 one clock later.
- R2: In equal-priority mode (`sched_mem_mode`=0), if `mshr_used` >= HI_MSHR or `missq_used` >= HI_MQ at a clock edge, `sched_mem_mode` reads 1 after that edge.
- R3: In memory-priority mode, the mode stays 1 while either occupancy is at or above its low threshold. It reads 0 after the first edge at which `mshr_used` < LO_MSHR and `missq_used` < LO_MQ.
- R4: If the warp issued last is still eligible, it is issued again, even when an older warp is also eligible. A warp is eligible when its ready bit is 1, its dependency bit is 0, and it is not barred by R7.
- R5: When the warp issued last is not eligible, the lowest-index eligible warp is issued.
- R6: If no warp is eligible at an edge, `issue_valid` is 0 after that edge.
- R7: In memory-priority mode, a warp whose `warp_is_mem` bit is 1 is issued only if it is the valid owner.
- R8: In memory-priority mode, a non-owner warp with `warp_is_mem`=0 that is ready and has no dependency is issued.
- R9: On entry to memory-priority mode, or while the owner slot is invalid, the owner becomes the lowest-index warp that is ready, has `warp_is_mem`=1 and has no dependency. If there is no such warp, `owner_valid` is 0.
- R10: When the owner's dependency bit is 1 in memory-priority mode, ownership passes by the R9 rule at that edge. The new owner can issue from the following edge.
- R11: `owner_valid` is 0 whenever `sched_mem_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | NUM_WARPS | Warp has a buffered instruction |
| warp_is_mem | input | NUM_WARPS | That instruction is a memory access |
| warp_dep_load | input | NUM_WARPS | That instruction waits on an outstanding load |
| mshr_used | input | OCC_W | Miss-status entries in use |
| missq_used | input | OCC_W | Miss-queue slots in use |
| issue_valid | output | 1 | A warp was issued |
| issue_warp | output | WID_W | Id of the issued warp |
| sched_mem_mode | output | 1 | 1 = memory-priority mode |
| owner_valid | output | 1 | Owner slot holds a warp |
| owner_warp | output | WID_W | Current owner warp id |

## Verification
Every output is registered, so all results are due one edge after the inputs that cause them. This holds for the issue choice, the mode change and the owner change alike. The bench changes inputs on the falling edge and reads outputs on the next falling edge, after exactly one rising edge. There is one two-step case: an issue decision at a given edge uses the mode and owner that were registered before that edge. So after a mode entry or an owner handover, the bench waits one more edge before it expects the new rule to show in `issue_warp`.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    MODE_EQUAL  = 1'b0,
    MODE_MEMPRI = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index is the oldest warp
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sat_mode_ctrl.sv
module sat_mode_ctrl
  import sched_pkg::*;
#(
  parameter int OCC_W   = 7,
  parameter int HI_MSHR = 56,
  parameter int LO_MSHR = 40,
  parameter int HI_MQ   = 28,
  parameter int LO_MQ   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] mshr_used,
  input  logic [OCC_W-1:0] missq_used,
  output sched_mode_e      mode,
  output sched_mode_e      mode_nxt
);
  localparam logic [OCC_W-1:0] HI_M = OCC_W'(HI_MSHR);
  localparam logic [OCC_W-1:0] LO_M = OCC_W'(LO_MSHR);
  localparam logic [OCC_W-1:0] HI_Q = OCC_W'(HI_MQ);
  localparam logic [OCC_W-1:0] LO_Q = OCC_W'(LO_MQ);

  logic press_hi, relief_lo;

  assign press_hi  = (mshr_used >= HI_M) || (missq_used >= HI_Q);
  assign relief_lo = (mshr_used < LO_M) && (missq_used < LO_Q);

  always_comb begin
    mode_nxt = mode;
    if (mode == MODE_EQUAL && press_hi)       mode_nxt = MODE_MEMPRI;
    else if (mode == MODE_MEMPRI && relief_lo) mode_nxt = MODE_EQUAL;
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_EQUAL;
    else     mode <= mode_nxt;
  end
endmodule

// File: rtl/warp_status.sv
module warp_status
  import sched_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  sched_mode_e   mode,
  input  logic          own_vld,
  input  logic [IW-1:0] own_id,
  input  logic [N-1:0]  ready,
  input  logic [N-1:0]  is_mem,
  input  logic [N-1:0]  dep,
  output logic [N-1:0]  stall,
  output logic [N-1:0]  mem_list
);
  for (genvar w = 0; w < N; w++) begin : g_warp
    logic barred;
    assign barred      = (mode == MODE_MEMPRI) && is_mem[w] &&
                         !(own_vld && own_id == IW'(w));
    assign stall[w]    = !ready[w] || dep[w] || barred;
    assign mem_list[w] = ready[w] && is_mem[w] && !dep[w];
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int OCC_W     = 7,
  parameter int HI_MSHR   = 56,
  parameter int LO_MSHR   = 40,
  parameter int HI_MQ     = 28,
  parameter int LO_MQ     = 16,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_is_mem,
  input  logic [NUM_WARPS-1:0] warp_dep_load,
  input  logic [OCC_W-1:0]     mshr_used,
  input  logic [OCC_W-1:0]     missq_used,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic                 sched_mem_mode,
  output logic                 owner_valid,
  output logic [WID_W-1:0]     owner_warp
);
  sched_mode_e          mode, mode_nxt;
  logic [NUM_WARPS-1:0] stall, mem_list;
  logic                 any_elig, mem_head_vld, hold_last;
  logic [WID_W-1:0]     oldest_elig, mem_head;

  sat_mode_ctrl #(
    .OCC_W(OCC_W), .HI_MSHR(HI_MSHR), .LO_MSHR(LO_MSHR),
    .HI_MQ(HI_MQ), .LO_MQ(LO_MQ)
  ) u_mode (
    .clk(clk), .rst(rst), .mshr_used(mshr_used), .missq_used(missq_used),
    .mode(mode), .mode_nxt(mode_nxt)
  );

  warp_status #(.N(NUM_WARPS), .IW(WID_W)) u_status (
    .mode(mode), .own_vld(owner_valid), .own_id(owner_warp),
    .ready(warp_ready), .is_mem(warp_is_mem), .dep(warp_dep_load),
    .stall(stall), .mem_list(mem_list)
  );

  oldest_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick_issue (
    .req(~stall), .found(any_elig), .idx(oldest_elig)
  );

  oldest_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick_owner (
    .req(mem_list), .found(mem_head_vld), .idx(mem_head)
  );

  assign hold_last      = issue_valid && !stall[issue_warp];
  assign sched_mem_mode = (mode == MODE_MEMPRI);

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      owner_valid <= 1'b0;
      owner_warp  <= '0;
    end else begin
      issue_valid <= hold_last || any_elig;
      if (!hold_last) issue_warp <= oldest_elig;

      if (mode_nxt == MODE_EQUAL) begin
        owner_valid <= 1'b0;
      end else if (!owner_valid || warp_dep_load[owner_warp]) begin
        owner_valid <= mem_head_vld;
        owner_warp  <= mem_head;
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int OCC_W     = 7,
  parameter int HI_MSHR   = 56,
  parameter int LO_MSHR   = 40,
  parameter int HI_MQ     = 28,
  parameter int LO_MQ     = 16,
  parameter int WID_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WARPS-1:0] warp_ready,
  input logic [NUM_WARPS-1:0] warp_is_mem,
  input logic [NUM_WARPS-1:0] warp_dep_load,
  input logic [OCC_W-1:0]     mshr_used,
  input logic [OCC_W-1:0]     missq_used,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_warp,
  input logic                 sched_mem_mode,
  input logic                 owner_valid,
  input logic [WID_W-1:0]     owner_warp
);
  localparam logic [OCC_W-1:0] HM = OCC_W'(HI_MSHR);
  localparam logic [OCC_W-1:0] LM = OCC_W'(LO_MSHR);
  localparam logic [OCC_W-1:0] HQ = OCC_W'(HI_MQ);
  localparam logic [OCC_W-1:0] LQ = OCC_W'(LO_MQ);

  logic [NUM_WARPS-1:0] rdy_q, mem_q, dep_q;
  logic                 mode_q, ownv_q;
  logic [WID_W-1:0]     own_q;

  always_ff @(posedge clk) begin
    rdy_q  <= warp_ready;
    mem_q  <= warp_is_mem;
    dep_q  <= warp_dep_load;
    mode_q <= sched_mem_mode;
    ownv_q <= owner_valid;
    own_q  <= owner_warp;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!issue_valid && !sched_mem_mode && !owner_valid));

  // R2
  enter_mempri_chk: assert property (@(posedge clk) disable iff (rst)
    (!sched_mem_mode && (mshr_used >= HM || missq_used >= HQ)) |=> sched_mem_mode);

  // R3
  hold_mempri_chk: assert property (@(posedge clk) disable iff (rst)
    (sched_mem_mode && !(mshr_used < LM && missq_used < LQ)) |=> sched_mem_mode);

  // R5
  issued_was_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (rdy_q[issue_warp] && !dep_q[issue_warp]));

  // R7
  mem_only_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && mode_q && mem_q[issue_warp]) |-> (ownv_q && own_q == issue_warp));

  // R11
  no_owner_equal_chk: assert property (@(posedge clk) disable iff (rst)
    !sched_mem_mode |-> !owner_valid);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .OCC_W(OCC_W), .HI_MSHR(HI_MSHR), .LO_MSHR(LO_MSHR),
  .HI_MQ(HI_MQ), .LO_MQ(LO_MQ), .WID_W(WID_W)
) u_chk (
  .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_is_mem(warp_is_mem),
  .warp_dep_load(warp_dep_load), .mshr_used(mshr_used), .missq_used(missq_used),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .sched_mem_mode(sched_mem_mode), .owner_valid(owner_valid),
  .owner_warp(owner_warp)
);

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;
  localparam int NW = 8;
  localparam int OW = 7;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] warp_ready = '0, warp_is_mem = '0, warp_dep_load = '0;
  logic [OW-1:0] mshr_used = '0, missq_used = '0;
  logic          issue_valid, sched_mem_mode, owner_valid;
  logic [IW-1:0] issue_warp, owner_warp;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_is_mem(warp_is_mem),
    .warp_dep_load(warp_dep_load), .mshr_used(mshr_used), .missq_used(missq_used),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .sched_mem_mode(sched_mem_mode), .owner_valid(owner_valid),
    .owner_warp(owner_warp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic warps(input logic [NW-1:0] r, input logic [NW-1:0] m,
                       input logic [NW-1:0] d);
    warp_ready = r; warp_is_mem = m; warp_dep_load = d;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    warps(8'hFF, 8'h00, 8'h00);
    mshr_used = 7'd100;
    cyc(); cyc();
    chk("R1 issue_valid", int'(issue_valid), 0);
    chk("R1 mode", int'(sched_mem_mode), 0);
    chk("R1 owner_valid", int'(owner_valid), 0);
    rst = 1'b0;
    mshr_used = '0;
    warps('0, '0, '0);
    cyc();
  endtask

  task automatic t_greedy();
    warps(8'b0010_0100, 8'h00, 8'h00); cyc();
    chk("R5 oldest first", int'(issue_warp), 2);
    cyc();
    chk("R4 keeps warp", int'(issue_warp), 2);
    warps(8'b0010_0000, 8'h00, 8'h00); cyc();
    chk("R5 switch when not ready", int'(issue_warp), 5);
    warps(8'b0010_0100, 8'h00, 8'h00); cyc();
    chk("R4 greedy over older", int'(issue_warp), 5);
    warps(8'b0010_0100, 8'h00, 8'b0010_0000); cyc();
    chk("R5 switch on dependency", int'(issue_warp), 2);
    warps('0, '0, '0); cyc();
    chk("R6 none eligible", int'(issue_valid), 0);
  endtask

  task automatic t_saturation();
    // warps 1,3 memory; 6 compute
    warps(8'b0100_1010, 8'b0000_1010, 8'h00);
    mshr_used = 7'd56; cyc();
    chk("R2 enter on mshr", int'(sched_mem_mode), 1);
    chk("R9 owner valid", int'(owner_valid), 1);
    chk("R9 owner oldest mem", int'(owner_warp), 1);
    mshr_used = 7'd45;
    warps(8'b0100_1000, 8'b0000_1010, 8'h00); cyc();
    chk("R3 hold above low", int'(sched_mem_mode), 1);
    chk("R8 compute non-owner issues", int'(issue_valid) * 10 + int'(issue_warp), 16);
    warps(8'b0000_1000, 8'b0000_1010, 8'h00); cyc();
    chk("R7 non-owner mem barred", int'(issue_valid), 0);
    warps(8'b0000_1010, 8'b0000_1010, 8'b0000_0010); cyc();
    chk("R10 owner handed over", int'(owner_warp), 3);
    chk("R7 old owner barred by dep", int'(issue_valid), 0);
    cyc();
    chk("R10 new owner issues", int'(issue_valid) * 10 + int'(issue_warp), 13);
    warps(8'b0000_1010, 8'b0000_1010, 8'b0000_1010); cyc();
    chk("R9 no candidate", int'(owner_valid), 0);
    mshr_used = 7'd30; missq_used = 7'd10; cyc();
    chk("R3 leave below both low", int'(sched_mem_mode), 0);
    chk("R11 owner cleared", int'(owner_valid), 0);
    missq_used = 7'd28; cyc();
    chk("R2 enter on miss queue", int'(sched_mem_mode), 1);
    chk("R9 entry without candidate", int'(owner_valid), 0);
    missq_used = 7'd20; cyc();
    chk("R3 hold on miss queue", int'(sched_mem_mode), 1);
    missq_used = 7'd0; mshr_used = 7'd0; cyc();
    chk("R3 leave again", int'(sched_mem_mode), 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_greedy();
    t_saturation();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule